// File: doc/BRIEF.md
# Watchdog and memory-routing control register

This block is one byte-wide special-function register of a small 8-bit microcontroller. It holds three groups of control bits. The first group sets the watchdog period. The second group routes data-pointer memory accesses to an on-chip EEPROM and allows byte writes into it. The third group selects which of two data-pointer banks is active. The CPU reads and writes the register through a simple byte bus at one fixed address. The other fields drive enable and select lines into the rest of the core.

The watchdog counts clock cycles while it is enabled. Its period is a base tick multiplied by a power of two chosen by a 3-bit prescaler field. When the count reaches the period and no restart has arrived, the block asserts a reset pulse for a fixed number of cycles.

Bit 1 has two roles. Writing 1 to it produces a one-cycle restart strobe to the watchdog, and the written value is never stored. Reading it returns the EEPROM ready flag, which is the inverse of an external busy input.

The block also issues EEPROM write requests to the external array. A request goes out only when a data-pointer write strobe arrives with both EEPROM routing and EEPROM write enable set, and the array is not busy.

Top module: `wdmc_top`

## Requirements
- R1: After reset, a read at address 0x96 returns 0x02 while `ee_busy` is low, and `ee_access_en`, `ee_wr_en`, `dp_bank_sel`, `ee_wr_req` and `wdt_rst` are all low.
- R2: The register fields are: bits 7:5 prescaler, bit 4 EEPROM write enable (drives `ee_wr_en`), bit 3 EEPROM routing (drives `ee_access_en`), bit 2 pointer-bank select (drives `dp_bank_sel`, 0 = bank at 0x82–0x83, 1 = bank at 0x84–0x85), bit 0 watchdog enable. Written values read back unchanged.
- R3: Bit 1 reads as 1 while `ee_busy` is low and as 0 while it is high. The value written to bit 1 is never stored.
- R4: Writing 1 to bit 1 clears the watchdog count on the clock edge after the write edge.
- R5: With the watchdog enabled, `wdt_rst` goes high once TICK_CYC·2^prescaler counting cycles pass without a restart. It stays high for RST_LEN cycles, and the count starts again from zero.
- R6: While bit 0 is 0 the count holds its value and `wdt_rst` does not rise. Enabling the watchdog again resumes from the held count.
- R7: A write that changes the prescaler field restarts the count on the following edge, and the new period applies from there.
- R8: `ee_wr_req` is high for the cycle after an edge on which `dp_wr` is high with bits 4 and 3 both set and `ee_busy` low. Otherwise it is low.
- R9: A data-pointer write with `ee_busy` high, or with bit 4 or bit 3 clear, produces no request.
- R10: Writes at any other address leave the register unchanged. Reads at any other address, or without `sfr_rd`, return 0x00.
- R11: If a restart strobe and watchdog expiry fall on the same edge, the restart wins and `wdt_rst` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wr | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data (combinational, 0 when not selected) |
| ee_busy | input | 1 | EEPROM programming in progress |
| dp_wr | input | 1 | Data-memory write through the data pointer |
| ee_wr_req | output | 1 | One-cycle byte-write request to the EEPROM array |
| ee_access_en | output | 1 | Route data-pointer accesses to on-chip EEPROM |
| ee_wr_en | output | 1 | EEPROM byte writes allowed |
| dp_bank_sel | output | 1 | Active data-pointer bank |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The restart strobe and the watchdog expiry can land on the same clock edge. The bench provokes this by enabling a 4-cycle period and then writing a restart so that its strobe arrives exactly on the expiry edge. It judges the result by checking that `wdt_rst` stays low there and rises only one full period later. The bench also overlaps a data-pointer write strobe with a busy array and expects no request.

// File: rtl/wdmc_pkg.sv
package wdmc_pkg;

    typedef struct packed {
        logic [2:0] ps;
        logic       mem_wr_en;
        logic       mem_sel;
        logic       bank_sel;
        logic       dog_en;
    } ctl_t;

    localparam ctl_t CTL_RST = '0;

    // Bit 1 of the visible byte carries the ready flag, not stored state.
    function automatic logic [7:0] ctl_to_byte(ctl_t c, logic ready);
        return {c.ps, c.mem_wr_en, c.mem_sel, c.bank_sel, ready, c.dog_en};
    endfunction

    function automatic ctl_t byte_to_ctl(logic [7:0] b);
        ctl_t c;
        c.ps        = b[7:5];
        c.mem_wr_en = b[4];
        c.mem_sel   = b[3];
        c.bank_sel  = b[2];
        c.dog_en    = b[0];
        return c;
    endfunction

endpackage

// File: rtl/wdmc_regs.sv
module wdmc_regs
    import wdmc_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'h96
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    input  logic       ee_busy,
    output ctl_t       ctl,
    output logic       restart,
    output logic [7:0] rdata
);

    logic hit;
    logic wr_hit;
    ctl_t nxt;

    assign hit    = (addr == REG_ADDR);
    assign wr_hit = wr && hit;
    assign nxt    = byte_to_ctl(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= CTL_RST;
            restart <= 1'b0;
        end else begin
            // strobe for kick bit or a new prescaler value, lasts one cycle
            restart <= wr_hit && (wdata[1] || (nxt.ps != ctl.ps));
            if (wr_hit) begin
                ctl <= nxt;
            end
        end
    end

    assign rdata = (rd && hit) ? ctl_to_byte(ctl, !ee_busy) : 8'h00;

    AST_FOREIGN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctl)); // R10

endmodule

// File: rtl/wdmc_wdog.sv
module wdmc_wdog #(
    parameter int unsigned TICK_CYC = 4,
    parameter int unsigned RST_LEN  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] ps,
    input  logic       restart,
    output logic       wdt_rst
);

    localparam int unsigned PER_MAX = TICK_CYC << 7;
    localparam int unsigned CNT_W   = $clog2(PER_MAX);
    localparam int unsigned PER_W   = CNT_W + 1;
    localparam int unsigned LEN_W   = $clog2(RST_LEN + 1);

    logic [CNT_W-1:0] cnt;
    logic [PER_W-1:0] per;
    logic [LEN_W-1:0] left;
    logic             last;
    logic             expire;

    assign per    = PER_W'(TICK_CYC) << ps;
    assign last   = ({1'b0, cnt} == (per - 1'b1));
    assign expire = en && !restart && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            left <= '0;
        end else begin
            if (restart) begin
                cnt <= '0;
            end else if (en) begin
                cnt <= last ? '0 : cnt + 1'b1;
            end
            if (expire) begin
                left <= LEN_W'(RST_LEN);
            end else if (left != '0) begin
                left <= left - 1'b1;
            end
        end
    end

    assign wdt_rst = (left != '0);

    AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0)); // R4
    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(cnt)); // R6
    AST_EXPIRY_FIRES: assert property (@(posedge clk) disable iff (rst)
        expire |=> wdt_rst); // R5
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (rst)
        restart |=> !$rose(wdt_rst)); // R11
    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        !restart |-> ({1'b0, cnt} < per)); // R5

endmodule

// File: rtl/wdmc_eereq.sv
module wdmc_eereq (
    input  logic clk,
    input  logic rst,
    input  logic dp_wr,
    input  logic mem_sel,
    input  logic mem_wr_en,
    input  logic ee_busy,
    output logic req
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req <= 1'b0;
        end else begin
            req <= dp_wr && mem_sel && mem_wr_en && !ee_busy;
        end
    end

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (rst)
        ee_busy |=> !req); // R9
    AST_REQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        !dp_wr |=> !req); // R8

endmodule

// File: rtl/wdmc_top.sv
module wdmc_top
    import wdmc_pkg::*;
#(
    parameter logic [7:0]  REG_ADDR = 8'h96,
    parameter int unsigned TICK_CYC = 4,
    parameter int unsigned RST_LEN  = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic       sfr_rd,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic       ee_busy,
    input  logic       dp_wr,
    output logic       ee_wr_req,
    output logic       ee_access_en,
    output logic       ee_wr_en,
    output logic       dp_bank_sel,
    output logic       wdt_rst
);

    ctl_t ctl;
    logic restart;

    wdmc_regs #(.REG_ADDR(REG_ADDR)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (sfr_addr),
        .wr      (sfr_wr),
        .rd      (sfr_rd),
        .wdata   (sfr_wdata),
        .ee_busy (ee_busy),
        .ctl     (ctl),
        .restart (restart),
        .rdata   (sfr_rdata)
    );

    wdmc_wdog #(.TICK_CYC(TICK_CYC), .RST_LEN(RST_LEN)) u_wdog (
        .clk     (clk),
        .rst     (rst),
        .en      (ctl.dog_en),
        .ps      (ctl.ps),
        .restart (restart),
        .wdt_rst (wdt_rst)
    );

    wdmc_eereq u_eereq (
        .clk       (clk),
        .rst       (rst),
        .dp_wr     (dp_wr),
        .mem_sel   (ctl.mem_sel),
        .mem_wr_en (ctl.mem_wr_en),
        .ee_busy   (ee_busy),
        .req       (ee_wr_req)
    );

    assign ee_access_en = ctl.mem_sel;
    assign ee_wr_en     = ctl.mem_wr_en;
    assign dp_bank_sel  = ctl.bank_sel;

endmodule

// File: tb/sim_wdmc_top.sv
module sim_wdmc_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic       sfr_rd = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       ee_busy = 1'b0;
    logic       dp_wr = 1'b0;
    logic       ee_wr_req, ee_access_en, ee_wr_en, dp_bank_sel, wdt_rst;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wdmc_top #(.REG_ADDR(8'h96), .TICK_CYC(4), .RST_LEN(3)) u0 (
        .clk, .rst, .sfr_addr, .sfr_wr, .sfr_rd, .sfr_wdata, .sfr_rdata,
        .ee_busy, .dp_wr, .ee_wr_req, .ee_access_en, .ee_wr_en,
        .dp_bank_sel, .wdt_rst
    );

    typedef struct packed {
        logic [7:0] wd;
        logic       busy;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h00, 1'b0, 8'h02},
        '{8'hFC, 1'b0, 8'hFE},
        '{8'h1E, 1'b1, 8'h1C},
        '{8'h06, 1'b0, 8'h06},
        '{8'hA8, 1'b1, 8'hA8},
        '{8'h54, 1'b0, 8'h56}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a; sfr_rd = 1'b1;
        #0.5;
        d = sfr_rdata;
        sfr_rd = 1'b0;
    endtask

    task automatic dp_pulse();
        @(negedge clk);
        dp_wr = 1'b1;
        @(negedge clk);
        dp_wr = 1'b0;
    endtask

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;

        // R1: reset state
        do_reset();
        sfr_read(8'h96, rv);
        chk("R1 reset read", rv, 8'h02);
        chk("R1 reset outputs", {ee_access_en, ee_wr_en, dp_bank_sel, ee_wr_req, wdt_rst}, 5'b0);

        // R2, R3: vector table, write then read back with the busy level set
        for (int i = 0; i < 6; i++) begin
            sfr_write(8'h96, VEC[i].wd);
            ee_busy = VEC[i].busy;
            sfr_read(8'h96, rv);
            chk("R2/R3 readback", rv, VEC[i].exp);
            chk("R2 outputs", {ee_wr_en, ee_access_en, dp_bank_sel},
                {VEC[i].wd[4], VEC[i].wd[3], VEC[i].wd[2]});
        end
        ee_busy = 1'b0;

        // R10: other address ignored, other reads zero
        do_reset();
        sfr_write(8'h95, 8'hFF);
        sfr_read(8'h96, rv);
        chk("R10 foreign write", rv, 8'h02);
        sfr_read(8'h95, rv);
        chk("R10 foreign read", rv, 8'h00);
        chk("R10 rdata idle", sfr_rdata, 8'h00);

        // R4, R5: period 4, reset pulse of 3
        do_reset();
        sfr_write(8'h96, 8'h03);
        repeat (4) @(negedge clk);
        chk("R5 before expiry", wdt_rst, 1'b0);
        @(negedge clk);
        chk("R5 expiry", wdt_rst, 1'b1);
        repeat (2) @(negedge clk);
        chk("R5 pulse held", wdt_rst, 1'b1);
        @(negedge clk);
        chk("R5 pulse ends", wdt_rst, 1'b0);

        // R5: largest prescaler, 512 cycles
        do_reset();
        sfr_write(8'h96, 8'hE3);
        repeat (512) @(negedge clk);
        chk("R5 ps7 before", wdt_rst, 1'b0);
        @(negedge clk);
        chk("R5 ps7 expiry", wdt_rst, 1'b1);

        // R6: disable holds count, resume continues it
        do_reset();
        sfr_write(8'h96, 8'h03);
        repeat (2) @(negedge clk);
        sfr_write(8'h96, 8'h00);
        repeat (20) @(negedge clk);
        chk("R6 no reset while off", wdt_rst, 1'b0);
        sfr_write(8'h96, 8'h01);
        chk("R6 resume edge", wdt_rst, 1'b0);
        @(negedge clk);
        chk("R6 resumes held count", wdt_rst, 1'b1);

        // R7: prescaler change restarts with new period 8
        do_reset();
        sfr_write(8'h96, 8'h03);
        @(negedge clk);
        sfr_write(8'h96, 8'h21);
        repeat (8) @(negedge clk);
        chk("R7 before new expiry", wdt_rst, 1'b0);
        @(negedge clk);
        chk("R7 new expiry", wdt_rst, 1'b1);

        // R11 and R4: kick lands on the expiry edge
        do_reset();
        sfr_write(8'h96, 8'h03);
        repeat (2) @(negedge clk);
        sfr_write(8'h96, 8'h03);
        @(negedge clk);
        chk("R11 kick beats expiry", wdt_rst, 1'b0);
        repeat (3) @(negedge clk);
        chk("R4 count restarted", wdt_rst, 1'b0);
        @(negedge clk);
        chk("R4 expiry after kick", wdt_rst, 1'b1);

        // R8, R9: EEPROM write requests
        do_reset();
        sfr_write(8'h96, 8'h18);
        dp_pulse();
        chk("R8 request", ee_wr_req, 1'b1);
        @(negedge clk);
        chk("R8 request one cycle", ee_wr_req, 1'b0);
        ee_busy = 1'b1;
        sfr_read(8'h96, rv);
        chk("R3 busy flag", rv[1], 1'b0);
        dp_pulse();
        chk("R9 busy blocks", ee_wr_req, 1'b0);
        ee_busy = 1'b0;
        sfr_write(8'h96, 8'h08);
        dp_pulse();
        chk("R9 no write enable", ee_wr_req, 1'b0);
        sfr_write(8'h96, 8'h10);
        dp_pulse();
        chk("R9 no routing", ee_wr_req, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule